// File: doc/BRIEF.md
# Big-Endian Load/Store Byte Lane Unit

This unit sits between a 32-bit core and a word-wide data memory that is addressed in bytes. Consecutive words lie four addresses apart, and each word is laid out big-endian, so the lowest address inside a word holds its most significant byte. On a load the unit picks the byte, halfword or word named by the address out of the memory read word, then extends it to 32 bits with either the sign bit or zeros. On a store it moves the low byte, the low halfword or the whole register value into the right lanes of the write word and builds a 4-bit byte-enable mask for the memory.

Every request is sampled on a rising clock edge when `req_valid_i` is high. The result appears on the registered outputs one cycle later, marked by `rsp_valid_o`. An access whose address does not suit its size raises `misalign_o`. Such an access writes no byte and returns no data.

Size encoding on `req_size_i`: 0 is byte, 1 is halfword, 2 is word, and 3 is reserved.

Top module: `be_lane_unit`

## Requirements
- R1: A request sampled with `req_valid_i`=1 produces `rsp_valid_o`=1 exactly one cycle later. The data, mask and flag outputs change only on such a response and hold their values while no request arrives.
- R2: While `rst_ni` is low, `rsp_valid_o`, `ld_data_o`, `st_data_o`, `st_be_o` and `misalign_o` are all zero.
- R3: A byte load (size 0) at offset k = addr[1:0] returns the read-word bits [31-8k : 24-8k], so offset 0 selects bits 31..24.
- R4: A halfword load (size 1) at offset 0 returns bits 31..16 and at offset 2 returns bits 15..0. A word load (size 2) at offset 0 returns the whole read word.
- R5: With `req_unsigned_i`=0, a byte or halfword load copies the top bit of the selected value into all higher bits of `ld_data_o`.
- R6: With `req_unsigned_i`=1, a byte or halfword load fills all bits of `ld_data_o` above the selected value with zeros.
- R7: A byte store at offset k places `wdata_i[7:0]` in bits [31-8k : 24-8k] of `st_data_o` and sets `st_be_o` to 4'b1000 >> k. Enable bit 3 covers bits 31..24; every other data bit is zero.
- R8: A halfword store places `wdata_i[15:0]` in bits 31..16 with `st_be_o`=4'b1100 at offset 0, and in bits 15..0 with `st_be_o`=4'b0011 at offset 2. The unused bits are zero.
- R9: An aligned word store passes `wdata_i` through unchanged and sets `st_be_o`=4'b1111.
- R10: A halfword access with addr[0]=1, a word access with addr[1:0]≠0, or any access with size 3 sets `misalign_o`=1. Its response then has `st_be_o`, `st_data_o` and `ld_data_o` all zero.
- R11: A load response always has `st_be_o`=0 and `st_data_o`=0. A store response always has `ld_data_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | AW | Byte address |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_unsigned_i | input | 1 | Load extends with zeros when 1, with the sign bit when 0 |
| rdata_i | input | 32 | Memory read word for loads |
| wdata_i | input | 32 | Register value for stores |
| rsp_valid_o | output | 1 | Registered result valid |
| ld_data_o | output | 32 | Extended load value |
| st_data_o | output | 32 | Positioned write word |
| st_be_o | output | 4 | Byte enables, bit 3 = bits 31..24 |
| misalign_o | output | 1 | Address does not suit the access size |

## Verification
Byte loads run at all four offsets against read words whose lanes are all different. Each lane also has a distinct top bit, so a wrong lane choice shows up, and so does a swap between sign and zero extension. Halfword and word accesses use words whose two halves differ in both value and sign. This tells the big-endian lane order apart from a little-endian one. Stores use register values with nonzero upper bytes, which shows that only the low byte or halfword is moved and that the untouched lanes are left clear. Every misaligned offset of each size, plus the reserved size, is run as both load and store. Idle gaps between requests show that the outputs hold their last values.

// File: rtl/be_lane_pkg.sv
package be_lane_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTES  = WORD_W / 8;
  localparam int unsigned OFF_W  = $clog2(BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/be_lane_align.sv
module be_lane_align
  import be_lane_pkg::*;
(
  input  logic [OFF_W-1:0] off_i,
  input  acc_size_e        size_i,
  output logic             misalign_o,
  output logic [BYTES-1:0] lane_mask_o
);
  logic [BYTES-1:0] lane_raw;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: misalign_o = 1'b0;
      SZ_HALF: misalign_o = off_i[0];
      SZ_WORD: misalign_o = |off_i;
      default: misalign_o = 1'b1;
    endcase
  end

  // lane l holds bits 8l+7:8l; big-endian offset of that lane is BYTES-1-l
  for (genvar l = 0; l < BYTES; l++) begin : g_lane
    localparam int unsigned LOFF = BYTES - 1 - l;
    always_comb begin
      unique case (size_i)
        SZ_BYTE: lane_raw[l] = (off_i == OFF_W'(LOFF));
        SZ_HALF: lane_raw[l] = (off_i[OFF_W-1:1] == (OFF_W-1)'(LOFF >> 1));
        SZ_WORD: lane_raw[l] = 1'b1;
        default: lane_raw[l] = 1'b0;
      endcase
    end
  end

  assign lane_mask_o = misalign_o ? '0 : lane_raw;
endmodule

// File: rtl/be_load_extract.sv
module be_load_extract
  import be_lane_pkg::*;
(
  input  logic [WORD_W-1:0] rdata_i,
  input  logic [OFF_W-1:0]  off_i,
  input  acc_size_e         size_i,
  input  logic              unsigned_i,
  output logic [WORD_W-1:0] data_o
);
  localparam int unsigned HALVES = BYTES / 2;

  logic [7:0]  byte_at [BYTES];
  logic [15:0] half_at [HALVES];
  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  for (genvar k = 0; k < BYTES; k++) begin : g_byte
    assign byte_at[k] = rdata_i[WORD_W-1-8*k -: 8];
  end
  for (genvar j = 0; j < HALVES; j++) begin : g_half
    assign half_at[j] = rdata_i[WORD_W-1-16*j -: 16];
  end

  assign sel_b = byte_at[off_i];
  assign sel_h = half_at[off_i[OFF_W-1:1]];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = {{(WORD_W-8){~unsigned_i & sel_b[7]}}, sel_b};
      SZ_HALF: data_o = {{(WORD_W-16){~unsigned_i & sel_h[15]}}, sel_h};
      SZ_WORD: data_o = rdata_i;
      default: data_o = '0;
    endcase
  end
endmodule

// File: rtl/be_store_place.sv
module be_store_place
  import be_lane_pkg::*;
(
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [BYTES-1:0]  lane_mask_i,
  input  acc_size_e         size_i,
  output logic [WORD_W-1:0] data_o
);
  for (genvar l = 0; l < BYTES; l++) begin : g_lane
    localparam int unsigned LOFF = BYTES - 1 - l;
    // within a halfword, the even offset carries the upper source byte
    localparam int unsigned HSRC = ((LOFF & 1) == 0) ? 1 : 0;
    logic [7:0] src;
    always_comb begin
      unique case (size_i)
        SZ_BYTE: src = wdata_i[7:0];
        SZ_HALF: src = wdata_i[8*HSRC +: 8];
        SZ_WORD: src = wdata_i[8*l +: 8];
        default: src = 8'h00;
      endcase
    end
    assign data_o[8*l +: 8] = lane_mask_i[l] ? src : 8'h00;
  end
endmodule

// File: rtl/be_lane_unit.sv
module be_lane_unit
  import be_lane_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_unsigned_i,
  input  logic [WORD_W-1:0] rdata_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              rsp_valid_o,
  output logic [WORD_W-1:0] ld_data_o,
  output logic [WORD_W-1:0] st_data_o,
  output logic [BYTES-1:0]  st_be_o,
  output logic              misalign_o
);
  acc_size_e        size;
  logic [OFF_W-1:0] off;
  logic             mis;
  logic [BYTES-1:0] mask;
  logic [WORD_W-1:0] ld_ext, st_pos;
  logic [WORD_W-1:0] ld_d, st_d;
  logic [BYTES-1:0]  be_d;

  assign size = acc_size_e'(req_size_i);
  assign off  = req_addr_i[OFF_W-1:0];

  be_lane_align u_align (
    .off_i       (off),
    .size_i      (size),
    .misalign_o  (mis),
    .lane_mask_o (mask)
  );

  be_load_extract u_extract (
    .rdata_i    (rdata_i),
    .off_i      (off),
    .size_i     (size),
    .unsigned_i (req_unsigned_i),
    .data_o     (ld_ext)
  );

  be_store_place u_place (
    .wdata_i     (wdata_i),
    .lane_mask_i (mask),
    .size_i      (size),
    .data_o      (st_pos)
  );

  always_comb begin
    ld_d = '0;
    st_d = '0;
    be_d = '0;
    if (req_write_i) begin
      st_d = st_pos;
      be_d = mask;
    end else if (!mis) begin
      ld_d = ld_ext;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      ld_data_o   <= '0;
      st_data_o   <= '0;
      st_be_o     <= '0;
      misalign_o  <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        ld_data_o  <= ld_d;
        st_data_o  <= st_d;
        st_be_o    <= be_d;
        misalign_o <= mis;
      end
    end
  end

  // R1
  p_rsp_follows_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_hold_when_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(ld_data_o) && $stable(st_be_o) && !rsp_valid_o));
  // R10
  p_misalign_no_be_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && misalign_o) |-> (st_be_o == '0 && ld_data_o == '0));
  // R11
  p_load_no_be_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> (st_be_o == '0 && st_data_o == '0));
  // R7
  p_byte_one_lane_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_size_i == 2'd0) |=> ($countones(st_be_o) == 1));
  // R9
  p_word_full_be_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_size_i == 2'd2 && req_addr_i[1:0] == 2'b00)
      |=> (st_be_o == '1));
  // R6
  p_zext_byte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && req_unsigned_i && req_size_i == 2'd0)
      |=> (ld_data_o[WORD_W-1:8] == '0));
  // R5
  p_sext_byte_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && !req_unsigned_i && req_size_i == 2'd0)
      |=> (ld_data_o[WORD_W-1:7] == '0 || ld_data_o[WORD_W-1:7] == '1));
endmodule

// File: tb/be_lane_unit_bench.sv
module be_lane_unit_bench;
  localparam int AW = 32;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [1:0]  req_size_i = 2'd0;
  logic        req_unsigned_i = 1'b0;
  logic [31:0] rdata_i = '0;
  logic [31:0] wdata_i = '0;
  logic        rsp_valid_o;
  logic [31:0] ld_data_o;
  logic [31:0] st_data_o;
  logic [3:0]  st_be_o;
  logic        misalign_o;

  always #5 clk_i = ~clk_i;

  be_lane_unit #(.AW(AW)) u_be_lane_unit (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_addr_i, .req_size_i,
    .req_unsigned_i, .rdata_i, .wdata_i, .rsp_valid_o, .ld_data_o,
    .st_data_o, .st_be_o, .misalign_o
  );

  typedef struct {
    logic [31:0] ld;
    logic [31:0] st;
    logic [3:0]  be;
    logic        mis;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_exp;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference model written from the requirements
  function automatic exp_t model(bit wr, logic [31:0] addr, logic [1:0] sz, bit uns,
                                 logic [31:0] rd, logic [31:0] wd, string tag);
    exp_t e;
    int   k;
    logic [31:0] v;
    k = int'(addr[1:0]);
    e.ld = 0; e.st = 0; e.be = 0; e.tag = tag;
    e.mis = (sz == 2'd3) || (sz == 2'd1 && addr[0]) || (sz == 2'd2 && k != 0);
    if (!e.mis) begin
      if (wr) begin
        case (sz)
          2'd0: begin e.st = {24'h0, wd[7:0]} << ((3 - k) * 8); e.be = 4'b0001 << (3 - k); end
          2'd1: begin e.st = {16'h0, wd[15:0]} << ((2 - k) * 8); e.be = 4'b0011 << (2 - k); end
          default: begin e.st = wd; e.be = 4'b1111; end
        endcase
      end else begin
        case (sz)
          2'd0: begin
            v = (rd >> ((3 - k) * 8)) & 32'hFF;
            e.ld = (!uns && v[7]) ? (v | 32'hFFFF_FF00) : v;
          end
          2'd1: begin
            v = (rd >> ((2 - k) * 8)) & 32'hFFFF;
            e.ld = (!uns && v[15]) ? (v | 32'hFFFF_0000) : v;
          end
          default: e.ld = rd;
        endcase
      end
    end
    return e;
  endfunction

  task automatic drive(bit wr, logic [31:0] addr, logic [1:0] sz, bit uns,
                       logic [31:0] rd, logic [31:0] wd, string tag);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = wr; req_addr_i = addr; req_size_i = sz;
    req_unsigned_i = uns; rdata_i = rd; wdata_i = wd;
    exp_q.push_back(model(wr, addr, sz, uns, rd, wd, tag));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      req_valid_i = 1'b0;
      rdata_i = 32'hDEAD_BEEF;
      wdata_i = 32'hFEED_FACE;
    end
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    forever begin
      @(negedge clk_i); #1;
      if (rst_ni && rsp_valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "unexpected response", 32'd1, 32'd0);
        end else begin
          e = exp_q.pop_front();
          last_exp = e;
          check(ld_data_o == e.ld, e.tag, "ld_data", ld_data_o, e.ld);
          check(st_data_o == e.st, e.tag, "st_data", st_data_o, e.st);
          check(st_be_o == e.be, e.tag, "st_be", {28'h0, st_be_o}, {28'h0, e.be});
          check(misalign_o == e.mis, e.tag, "misalign", {31'h0, misalign_o}, {31'h0, e.mis});
        end
      end
    end
  end

  // watchdog
  initial begin
    #200000;
    if (!done) begin
      check(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R2: reset state
    #12;
    check(rsp_valid_o == 0 && st_be_o == 0 && misalign_o == 0, "R2", "reset ctrl",
          {27'h0, rsp_valid_o, st_be_o}, 32'd0);
    check(ld_data_o == 0 && st_data_o == 0, "R2", "reset data", ld_data_o | st_data_o, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R3 R5 R6: byte loads, every lane with a different top bit
    for (int k = 0; k < 4; k++) begin
      drive(0, 32'h100 + k, 2'd0, 0, 32'h81_42_C3_24, 0, "R5");
      drive(0, 32'h100 + k, 2'd0, 1, 32'h81_42_C3_24, 0, "R6");
      drive(0, 32'h200 + k, 2'd0, 0, 32'h12_F3_54_95, 0, "R3");
    end
    // R4: halfword and word loads
    drive(0, 32'h10, 2'd1, 0, 32'h8001_7FFE, 0, "R4");
    drive(0, 32'h12, 2'd1, 0, 32'h8001_7FFE, 0, "R4");
    drive(0, 32'h12, 2'd1, 0, 32'h1234_9ABC, 0, "R5");
    drive(0, 32'h10, 2'd1, 1, 32'h8001_7FFE, 0, "R6");
    drive(0, 32'h12, 2'd1, 1, 32'h1234_9ABC, 0, "R6");
    drive(0, 32'h14, 2'd2, 0, 32'hCAFE_0123, 0, "R4");
    drive(0, 32'h14, 2'd2, 1, 32'h8765_4321, 0, "R4");
    // R7 R8 R9: stores with nonzero upper register bytes
    for (int k = 0; k < 4; k++)
      drive(1, 32'h300 + k, 2'd0, 0, 0, 32'hA1B2_C3D4, "R7");
    drive(1, 32'h40, 2'd1, 0, 0, 32'h5566_7788, "R8");
    drive(1, 32'h42, 2'd1, 0, 0, 32'h5566_7788, "R8");
    drive(1, 32'h44, 2'd2, 0, 0, 32'h0BAD_F00D, "R9");
    // R11: loads clear store side, stores clear load side
    drive(0, 32'h44, 2'd2, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R11");
    drive(1, 32'h44, 2'd2, 0, 32'hFFFF_FFFF, 32'h1357_9BDF, "R11");
    // R10: misaligned and reserved size, load and store
    for (int k = 1; k < 4; k += 2) begin
      drive(0, 32'h50 + k, 2'd1, 0, 32'hFFFF_FFFF, 0, "R10");
      drive(1, 32'h50 + k, 2'd1, 0, 0, 32'hFFFF_FFFF, "R10");
    end
    for (int k = 1; k < 4; k++) begin
      drive(0, 32'h60 + k, 2'd2, 0, 32'h89AB_CDEF, 0, "R10");
      drive(1, 32'h60 + k, 2'd2, 0, 0, 32'h89AB_CDEF, "R10");
    end
    for (int k = 0; k < 4; k++) begin
      drive(0, 32'h70 + k, 2'd3, 1, 32'h1111_1111, 0, "R10");
      drive(1, 32'h70 + k, 2'd3, 1, 0, 32'h2222_2222, "R10");
    end
    // R1: back-to-back, then gaps; last word store leaves known outputs
    drive(1, 32'h80, 2'd2, 0, 0, 32'h600D_CAFE, "R1");
    idle(1);
    drive(0, 32'h81, 2'd0, 1, 32'h00A5_0000, 0, "R1");
    drive(1, 32'h82, 2'd1, 0, 0, 32'h0000_BEEF, "R1");
    idle(4);
    // R1: outputs hold while idle
    check(exp_q.size() == 0, "R1", "pending responses", exp_q.size(), 32'd0);
    check(rsp_valid_o == 1'b0, "R1", "valid while idle", {31'h0, rsp_valid_o}, 32'd0);
    check(st_data_o == last_exp.st && st_be_o == last_exp.be, "R1", "hold st_data",
          st_data_o, last_exp.st);
    check(ld_data_o == last_exp.ld, "R1", "hold ld_data", ld_data_o, last_exp.ld);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule